// File: doc/BRIEF.md
# Hardware-Armed Windowed Watchdog

This block is a supervision timer that starts counting as soon as reset is released. No software action is needed to arm it. Software must service it with a keyed strobe inside a time window. The window opens at a programmable count and closes at a programmable timeout. Three things count as a fault: a strobe that arrives before the window opens, a strobe carrying the wrong key, or no valid strobe before the timeout.

A fault raises an interrupt. Software then has a fixed grace period to acknowledge the fault with a correctly keyed strobe. If it does not, the block issues a one-cycle reset request to the system reset logic.

The window-open and timeout counts can be written once after each reset, through a single configuration write. The block then locks them until the next reset. If that write never happens, the reset defaults still give full protection: the window is open from count 0 and the timeout is 1024 cycles.

Top module: `wwdt_guard`

## Requirements
- R1: While reset is asserted and directly after it, `fault_irq` and `rst_req` are low. The cycle counter starts at zero and runs with no software start.
- R2: With no configuration write, the window opens at count 0 and the timeout is 1024. If no strobe arrives, `fault_irq` rises at the 1024th rising edge after reset release.
- R3: The first `cfg_wr` after reset loads `cfg_open` as the window-open count and `cfg_limit` as the timeout, then locks the configuration. A strobe sampled on the same edge is still judged against the previous values.
- R4: Any later `cfg_wr` before the next reset has no effect on the window-open count or the timeout.
- R5: A strobe is valid when `svc_valid` is high, `svc_key` equals 8'hA5, and the counter is at or above the window-open count. A valid strobe restarts the counter at zero and raises no fault.
- R6: A correctly keyed strobe sampled while the counter is below the window-open count sets `fault_irq` on that edge.
- R7: A strobe whose key is not 8'hA5 sets `fault_irq` on that edge, whatever the count.
- R8: If the counter is at timeout-1 on an edge with no strobe, `fault_irq` is set on that edge. A valid strobe on that same edge takes priority and is accepted.
- R9: While `fault_irq` is high, a strobe keyed 8'hA5 clears it and restarts the counter at zero. A wrongly keyed strobe during a fault is ignored.
- R10: If a fault stays uncleared for 16 cycles (the GRACE parameter), `rst_req` pulses high for exactly one cycle. `fault_irq` drops in that same cycle, and counting resumes from zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| svc_valid | input | 1 | Service strobe |
| svc_key | input | 8 | Key carried by the service strobe |
| cfg_wr | input | 1 | One-time configuration write |
| cfg_open | input | 16 | Window-open count to load |
| cfg_limit | input | 16 | Timeout count to load |
| fault_irq | output | 1 | Fault interrupt, held until acknowledged or escalated |
| rst_req | output | 1 | One-cycle system reset request |

## Verification
The main function is tried with strobes placed at distinct counts: at zero, just below the window-open count, at its exact value, mid-window and on the last cycle before timeout. Together these separate an off-by-one in the window compare from an error in timeout priority. Correct and wrong keys at in-window counts show that the key check is independent of timing. A late second configuration write is followed by an early strobe and an idle run to timeout, which shows the lock at the fault output. An unacknowledged fault, with a wrong-key strobe inside it, fixes the exact grace length and the width of the reset pulse. A fresh reset with no configuration measures the default timeout to the cycle.

// File: rtl/wwdt_guard.sv
`timescale 1ns/1ps
module wwdt_guard #(
  parameter int CNT_W = 16,
  parameter int KEY_W = 8,
  parameter logic [KEY_W-1:0] KEY = 8'hA5,
  parameter int DEF_OPEN = 0,
  parameter int DEF_LIMIT = 1024,
  parameter int GRACE = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             svc_valid,
  input  logic [KEY_W-1:0] svc_key,
  input  logic             cfg_wr,
  input  logic [CNT_W-1:0] cfg_open,
  input  logic [CNT_W-1:0] cfg_limit,
  output logic             fault_irq,
  output logic             rst_req
);
  localparam int GW = (GRACE > 1) ? $clog2(GRACE) : 1;

  logic [CNT_W-1:0] cnt, open_r, limit_r;
  logic [GW-1:0]    grace;
  logic             locked, fault, rst_q;

  wire key_ok    = (svc_key == KEY);
  wire svc_good  = svc_valid && key_ok && (cnt >= open_r);
  wire expire    = ({1'b0, cnt} + (CNT_W+1)'(1)) >= {1'b0, limit_r};
  wire grace_end = (grace == GW'(GRACE - 1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      open_r  <= CNT_W'(DEF_OPEN);
      limit_r <= CNT_W'(DEF_LIMIT);
      locked  <= 1'b0;
    end else if (cfg_wr && !locked) begin
      open_r  <= cfg_open;
      limit_r <= cfg_limit;
      locked  <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt   <= '0;
      fault <= 1'b0;
      grace <= '0;
      rst_q <= 1'b0;
    end else begin
      rst_q <= 1'b0;
      if (fault) begin
        if (svc_valid && key_ok) begin
          fault <= 1'b0;
          cnt   <= '0;
          grace <= '0;
        end else if (grace_end) begin
          fault <= 1'b0;
          rst_q <= 1'b1;
          cnt   <= '0;
          grace <= '0;
        end else begin
          grace <= grace + GW'(1);
        end
      end else if (svc_valid) begin
        cnt <= '0;
        if (!svc_good) begin
          fault <= 1'b1;
          grace <= '0;
        end
      end else if (expire) begin
        fault <= 1'b1;
        cnt   <= '0;
        grace <= '0;
      end else begin
        cnt <= cnt + CNT_W'(1);
      end
    end
  end

  assign fault_irq = fault;
  assign rst_req   = rst_q;
endmodule

// File: rtl/wwdt_guard_chk.sv
`timescale 1ns/1ps
module wwdt_guard_chk #(
  parameter int CNT_W = 16,
  parameter int KEY_W = 8,
  parameter logic [KEY_W-1:0] KEY = 8'hA5
) (
  input logic             clk,
  input logic             rst_n,
  input logic             svc_valid,
  input logic [KEY_W-1:0] svc_key,
  input logic             fault_irq,
  input logic             rst_req,
  input logic [CNT_W-1:0] cnt,
  input logic [CNT_W-1:0] open_r,
  input logic [CNT_W-1:0] limit_r,
  input logic             locked
);
  a_r4_cfg_locked: assert property (@(posedge clk) disable iff (!rst_n)
    locked |=> ($stable(open_r) && $stable(limit_r)));

  a_r5_good_restart: assert property (@(posedge clk) disable iff (!rst_n)
    (!fault_irq && svc_valid && svc_key == KEY && cnt >= open_r) |=> (!fault_irq && cnt == '0));

  a_r6_early_fault: assert property (@(posedge clk) disable iff (!rst_n)
    (!fault_irq && svc_valid && svc_key == KEY && cnt < open_r) |=> fault_irq);

  a_r7_bad_key_fault: assert property (@(posedge clk) disable iff (!rst_n)
    (!fault_irq && svc_valid && svc_key != KEY) |=> fault_irq);

  a_r8_timeout_fault: assert property (@(posedge clk) disable iff (!rst_n)
    (!fault_irq && !svc_valid && ({1'b0, cnt} + (CNT_W+1)'(1)) == {1'b0, limit_r}) |=> fault_irq);

  a_r9_ack_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (fault_irq && svc_valid && svc_key == KEY) |=> (!fault_irq && !rst_req));

  a_r10_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    rst_req |=> !rst_req);

  a_r10_after_fault: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_req) |-> ($past(fault_irq) && !fault_irq));
endmodule

bind wwdt_guard wwdt_guard_chk #(.CNT_W(CNT_W), .KEY_W(KEY_W), .KEY(KEY)) u_chk (
  .clk(clk), .rst_n(rst_n), .svc_valid(svc_valid), .svc_key(svc_key),
  .fault_irq(fault_irq), .rst_req(rst_req), .cnt(cnt), .open_r(open_r),
  .limit_r(limit_r), .locked(locked)
);

// File: tb/test_wwdt_guard.sv
`timescale 1ns/1ps
module test_wwdt_guard;
  localparam logic [7:0] K = 8'hA5;

  logic clk = 0, rst_n = 0, svc_valid = 0, cfg_wr = 0;
  logic [7:0] svc_key = 0;
  logic [15:0] cfg_open = 0, cfg_limit = 0;
  logic fault_irq, rst_req;
  int checks = 0, errs = 0;
  bit done = 0;

  always #4 clk = ~clk;

  wwdt_guard i_wwdt_guard (
    .clk(clk), .rst_n(rst_n), .svc_valid(svc_valid), .svc_key(svc_key),
    .cfg_wr(cfg_wr), .cfg_open(cfg_open), .cfg_limit(cfg_limit),
    .fault_irq(fault_irq), .rst_req(rst_req)
  );

  // delay, key, expected fault
  localparam logic [16:0] VEC [9] = '{
    {8'd20, K, 1'b0}, {8'd19, K, 1'b1}, {8'd0, K, 1'b1},
    {8'd59, K, 1'b0}, {8'd35, K, 1'b0}, {8'd30, 8'h5A, 1'b1},
    {8'd40, 8'h00, 1'b1}, {8'd21, K, 1'b0}, {8'd58, K, 1'b0}
  };

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic chk(string req, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s: got %b expected %b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic service(int d, logic [7:0] key);
    repeat (d) tick();
    svc_valid = 1; svc_key = key;
    tick();
    svc_valid = 0; svc_key = 0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", checks, errs);
      $finish;
    end
  endtask

  initial begin
    #(8 * 150000);
    errs++; checks++;
    $display("FAIL watchdog: got hang expected completion");
    finish_run();
  end

  initial begin
    repeat (3) tick();
    chk("R1 fault in reset", fault_irq, 1'b0);
    chk("R1 rst_req in reset", rst_req, 1'b0);
    rst_n = 1;
    cfg_wr = 1; cfg_open = 16'd20; cfg_limit = 16'd60;
    svc_valid = 1; svc_key = K;
    tick();
    cfg_wr = 0; svc_valid = 0; svc_key = 0;
    chk("R3 strobe at count 0 with old open", fault_irq, 1'b0);

    for (int i = 0; i < 9; i++) begin
      int d;
      logic [7:0] key;
      logic exp;
      string tag;
      d = int'(VEC[i][16:9]); key = VEC[i][8:1]; exp = VEC[i][0];
      tag = !exp ? (d == 59 ? "R8 last-cycle service" : "R5 valid service")
                 : (key != K ? "R7 wrong key" : "R6 early service");
      service(d, key);
      chk(tag, fault_irq, exp);
      if (exp) begin
        service(0, K);
        chk("R9 ack clears fault", fault_irq, 1'b0);
      end
    end

    cfg_wr = 1; cfg_open = 16'd0; cfg_limit = 16'd5000;
    tick();
    cfg_wr = 0;
    service(4, K);
    chk("R4 open unchanged after late write", fault_irq, 1'b1);
    service(0, K);
    chk("R9 ack clears fault", fault_irq, 1'b0);

    repeat (59) tick();
    chk("R8 no fault before timeout", fault_irq, 1'b0);
    tick();
    chk("R8 fault at timeout (R4 limit kept)", fault_irq, 1'b1);

    repeat (4) tick();
    service(0, 8'h3C);
    repeat (10) tick();
    chk("R9 wrong key ignored in fault", fault_irq, 1'b1);
    chk("R10 no reset before grace end", rst_req, 1'b0);
    tick();
    chk("R10 reset request pulse", rst_req, 1'b1);
    chk("R10 fault drops with request", fault_irq, 1'b0);
    tick();
    chk("R10 request one cycle", rst_req, 1'b0);
    service(19, K);
    chk("R10 counting resumes from zero", fault_irq, 1'b0);

    rst_n = 0;
    repeat (2) tick();
    rst_n = 1;
    repeat (1023) tick();
    chk("R2 no fault before default timeout", fault_irq, 1'b0);
    tick();
    chk("R2 fault at default timeout", fault_irq, 1'b1);
    finish_run();
  end
endmodule